// File: doc/BRIEF.md
# MMU Control and Fault Register Block

This block is the register front end of a system MMU placed in front of a single bus master. Software reaches it through a word-addressed read/write port. Through that port it sets the operating mode, selects the first-level table size, loads the page-table base, requests a TLB invalidate, and services faults. The translation engine reports fault events to the block. Each event carries a type code and the faulting address. The block records each event as a sticky status bit, keeps the faulting address in one of four shared address registers, raises an interrupt, and stalls the master until software releases it.

The unit has three modes. In the off mode, requests pass through untranslated. In the translating mode, requests are accepted and translated. In the blocked mode, requests are held. Any fault that is accepted moves the unit into the blocked mode. The unit stays there until software writes the translating code to the control register.

Top module: `mmu_ctl_regs`

## Requirements
- R1: The control register (word offset 0) accepts three codes: 0x0 selects off, 0x5 selects translating and 0x7 selects blocked. The new mode applies from the next clock. A read returns the current code. Any other written value leaves the mode unchanged.
- R2: Exactly one of `bypass`, `req_ready` and `blocked` is high at any time. `bypass` is high in the off mode, `req_ready` is high in the translating mode, and `blocked` is high in the blocked mode.
- R3: The status register (offset 4, read-only) has eight bits. A fault of type t (`flt_type`) sets bit t. The bits are, from 0 to 7: page fault, read multi-hit, write multi-hit, bus error, read security, read access, write security, write access. An accepted fault also puts the unit in the blocked mode on the next clock. A fault reported while the unit is off is ignored.
- R4: When a fault and a control-register write arrive in the same cycle, the fault wins and the unit ends up blocked.
- R5: The faulting address is stored in one of four registers, chosen by type. Type 0 goes to offset 6. Types 1, 4 and 5 go to offset 7. Types 2, 6 and 7 go to offset 8. Type 3 goes to offset 9.
- R6: An address register is loaded only if none of the status bits in its group is already set. A later fault in the same group therefore keeps the earlier address.
- R7: Writing to the clear register (offset 5) clears each status bit whose position holds a one in the written value. A fault that sets a bit in the same cycle as a clear of that bit leaves the bit set.
- R8: `irq` is high exactly when at least one status bit is set and the unit is not off.
- R9: A write to the flush register (offset 3) with bit 0 set makes `tlb_flush` high for exactly the one cycle after the write. Other writes leave `tlb_flush` low.
- R10: In the configuration register (offset 1), bit 5 selects the table size. Writing 0x20 drives `tbl_small` high, which selects a 4 KB first-level table. Writing 0x0 drives it low, which selects a 16 KB table. A read returns the bit in place.
- R11: The base register (offset 2) holds the full written word. It drives `pt_base` and reads back unchanged. It changes only on a write to offset 2.
- R12: After reset the unit is off, and status, configuration, base and all four address registers are zero. `tlb_flush` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from `reg_addr` |
| flt_valid | input | 1 | Fault event from the translation engine |
| flt_type | input | 3 | Fault type code (status bit position) |
| flt_addr | input | DW | Faulting address |
| irq | output | 1 | Fault interrupt |
| req_ready | output | 1 | Upstream request ready (translating mode only) |
| bypass | output | 1 | Requests pass untranslated (off mode) |
| blocked | output | 1 | Translation stalled |
| tlb_flush | output | 1 | One-cycle invalidate-all pulse |
| tbl_small | output | 1 | 1: 4 KB first-level table, 0: 16 KB |
| pt_base | output | DW | First-level table base address |

## Verification
The bench sweeps all eight fault types. For each type it checks the status bit, the entry into the blocked mode and the routed address register. It then sends a second fault into the same group while the first is still pending. This catches a design that routes by the wrong group, or one that overwrites the earlier address. It also drives the same-cycle races. An unblock write arriving together with a fault must leave the unit blocked, where a design with the wrong priority would resume translation. A clear arriving together with a new fault of the same type must keep the bit, where the wrong priority would lose the fault silently. Finally, it confirms that faults are dropped while the unit is off, that the interrupt is masked while off, and that invalid control codes and flush writes without bit 0 have no effect at the ports.

// File: rtl/mmu_ctl_pkg.sv
// Package: shared types, register offsets and fault grouping for the MMU
// control block. Assumes a word-addressed register port of REG_AW bits.
package mmu_ctl_pkg;

    localparam int REG_AW  = 4;
    localparam int NUM_FLT = 8;
    localparam int NUM_GRP = 4;
    localparam int FLT_TW  = $clog2(NUM_FLT);
    localparam int GRP_W   = $clog2(NUM_GRP);

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_XLATE = 2'd1,
        ST_BLOCK = 2'd2
    } ctl_state_e;

    localparam logic [REG_AW-1:0] RA_CTRL   = 4'd0;
    localparam logic [REG_AW-1:0] RA_CFG    = 4'd1;
    localparam logic [REG_AW-1:0] RA_BASE   = 4'd2;
    localparam logic [REG_AW-1:0] RA_FLUSH  = 4'd3;
    localparam logic [REG_AW-1:0] RA_STATUS = 4'd4;
    localparam logic [REG_AW-1:0] RA_CLEAR  = 4'd5;
    localparam logic [REG_AW-1:0] RA_ADDR0  = 4'd6;

    localparam logic [7:0] CODE_OFF   = 8'h00;
    localparam logic [7:0] CODE_XLATE = 8'h05;
    localparam logic [7:0] CODE_BLOCK = 8'h07;

    localparam int CFG_SMALL_BIT = 5;

    // Group index for a fault type: 0 page, 1 read side, 2 write side, 3 bus error
    function automatic logic [GRP_W-1:0] flt_group(input logic [FLT_TW-1:0] t);
        case (t)
            3'd0:                  return 2'd0;
            3'd1, 3'd4, 3'd5:      return 2'd1;
            3'd2, 3'd6, 3'd7:      return 2'd2;
            default:               return 2'd3;
        endcase
    endfunction

    // Status bits that belong to a group
    function automatic logic [NUM_FLT-1:0] grp_mask(input logic [GRP_W-1:0] g);
        logic [NUM_FLT-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_FLT; i++) begin
            if (flt_group(FLT_TW'(i)) == g) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/mmu_ctl_state.sv
// Mode register: off / translating / blocked.
// Assumes fault_evt is already qualified (not raised while off).
// An accepted fault overrides a same-cycle control write.
module mmu_ctl_state
    import mmu_ctl_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [DW-1:0]    ctrl_wdata,
    input  logic             fault_evt,
    output ctl_state_e       state
);

    ctl_state_e state_nxt;

    // Next mode: fault first, then a valid control code, else hold
    always_comb begin
        state_nxt = state;
        if (fault_evt) begin
            state_nxt = ST_BLOCK;
        end else if (ctrl_wr) begin
            if (ctrl_wdata == DW'(CODE_OFF))        state_nxt = ST_OFF;
            else if (ctrl_wdata == DW'(CODE_XLATE)) state_nxt = ST_XLATE;
            else if (ctrl_wdata == DW'(CODE_BLOCK)) state_nxt = ST_BLOCK;
        end
    end

    // Mode register with synchronous reset to off
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

endmodule

// File: rtl/mmu_ctl_fault.sv
// Fault status and address capture.
// Keeps eight sticky status bits (set by fault, write-one-to-clear) and one
// address register per fault group. A group's address is loaded only while
// no status bit of that group is pending (judged on the pre-clear value).
module mmu_ctl_fault
    import mmu_ctl_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fault_evt,
    input  logic [FLT_TW-1:0]             flt_type,
    input  logic [DW-1:0]                 flt_addr,
    input  logic                          clr_wr,
    input  logic [NUM_FLT-1:0]            clr_mask,
    output logic [NUM_FLT-1:0]            status,
    output logic [NUM_GRP-1:0][DW-1:0]    grp_addr
);

    logic [NUM_FLT-1:0] set_mask;
    logic [NUM_FLT-1:0] clr_eff;
    logic [GRP_W-1:0]   evt_grp;

    // Decode the set and clear masks for this cycle
    always_comb begin
        set_mask = '0;
        if (fault_evt) set_mask[flt_type] = 1'b1;
        clr_eff  = clr_wr ? clr_mask : '0;
        evt_grp  = flt_group(flt_type);
    end

    // Status bits: set has priority over clear on the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_eff) | set_mask;
    end

    // One address register per group
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_addr
        localparam logic [NUM_FLT-1:0] GMASK = grp_mask(GRP_W'(g));
        logic capture;

        // Load when this group is targeted and nothing in it is pending
        always_comb begin
            capture = fault_evt && (evt_grp == GRP_W'(g)) && ((status & GMASK) == '0);
        end

        // Address holding register
        always_ff @(posedge clk) begin
            if (!rst_n)       grp_addr[g] <= '0;
            else if (capture) grp_addr[g] <= flt_addr;
        end
    end

endmodule

// File: rtl/mmu_ctl_cfg.sv
// Configuration, page-table base and TLB flush pulse.
// Only bit CFG_SMALL_BIT of the configuration word is stored. The flush
// pulse is registered and lasts one cycle per qualifying write.
module mmu_ctl_cfg
    import mmu_ctl_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          base_wr,
    input  logic          flush_wr,
    input  logic [DW-1:0] wdata,
    output logic          tbl_small,
    output logic [DW-1:0] pt_base,
    output logic          tlb_flush
);

    // Table-size select
    always_ff @(posedge clk) begin
        if (!rst_n)      tbl_small <= 1'b0;
        else if (cfg_wr) tbl_small <= wdata[CFG_SMALL_BIT];
    end

    // First-level table base
    always_ff @(posedge clk) begin
        if (!rst_n)       pt_base <= '0;
        else if (base_wr) pt_base <= wdata;
    end

    // Invalidate-all pulse, one cycle after a flush write with bit 0 set
    always_ff @(posedge clk) begin
        if (!rst_n) tlb_flush <= 1'b0;
        else        tlb_flush <= flush_wr && wdata[0];
    end

endmodule

// File: rtl/mmu_ctl_regs.sv
// Top: register decode, read mux and mode outputs of the MMU control block.
// Assumes one bus master and a translation engine that reports at most one
// fault per cycle. Faults are accepted only while the unit is not off.
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              flt_valid,
    input  logic [FLT_TW-1:0] flt_type,
    input  logic [DW-1:0]     flt_addr,
    output logic              irq,
    output logic              req_ready,
    output logic              bypass,
    output logic              blocked,
    output logic              tlb_flush,
    output logic              tbl_small,
    output logic [DW-1:0]     pt_base
);

    ctl_state_e                 state_q;
    logic [NUM_FLT-1:0]         status_q;
    logic [NUM_GRP-1:0][DW-1:0] grp_addr;
    logic                       fault_evt;
    logic                       wr_ctrl, wr_cfg, wr_base, wr_flush, wr_clear;
    logic [7:0]                 ctrl_code;

    // Write decode and fault qualification
    always_comb begin
        wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
        wr_cfg    = reg_wr && (reg_addr == RA_CFG);
        wr_base   = reg_wr && (reg_addr == RA_BASE);
        wr_flush  = reg_wr && (reg_addr == RA_FLUSH);
        wr_clear  = reg_wr && (reg_addr == RA_CLEAR);
        fault_evt = flt_valid && (state_q != ST_OFF);
    end

    mmu_ctl_state #(.DW(DW)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (wr_ctrl),
        .ctrl_wdata (reg_wdata),
        .fault_evt  (fault_evt),
        .state      (state_q)
    );

    mmu_ctl_fault #(.DW(DW)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_evt (fault_evt),
        .flt_type  (flt_type),
        .flt_addr  (flt_addr),
        .clr_wr    (wr_clear),
        .clr_mask  (reg_wdata[NUM_FLT-1:0]),
        .status    (status_q),
        .grp_addr  (grp_addr)
    );

    mmu_ctl_cfg #(.DW(DW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (wr_cfg),
        .base_wr   (wr_base),
        .flush_wr  (wr_flush),
        .wdata     (reg_wdata),
        .tbl_small (tbl_small),
        .pt_base   (pt_base),
        .tlb_flush (tlb_flush)
    );

    // Mode outputs and interrupt
    always_comb begin
        bypass    = (state_q == ST_OFF);
        req_ready = (state_q == ST_XLATE);
        blocked   = (state_q == ST_BLOCK);
        irq       = (|status_q) && (state_q != ST_OFF);
        case (state_q)
            ST_XLATE: ctrl_code = CODE_XLATE;
            ST_BLOCK: ctrl_code = CODE_BLOCK;
            default:  ctrl_code = CODE_OFF;
        endcase
    end

    // Read mux; write-only registers read as zero
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:   reg_rdata[7:0] = ctrl_code;
            RA_CFG:    reg_rdata[CFG_SMALL_BIT] = tbl_small;
            RA_BASE:   reg_rdata = pt_base;
            RA_STATUS: reg_rdata[NUM_FLT-1:0] = status_q;
            default: begin
                for (int g = 0; g < NUM_GRP; g++) begin
                    if (reg_addr == RA_ADDR0 + REG_AW'(g)) reg_rdata = grp_addr[g];
                end
            end
        endcase
    end

endmodule

// File: rtl/mmu_ctl_chk.sv
// Checker for mmu_ctl_regs: temporal properties on mode, status and pulses.
// Attached to every instance of the top through the bind at the end.
module mmu_ctl_chk
    import mmu_ctl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [7:0]         wdata_lo,
    input logic               flt_valid,
    input logic [FLT_TW-1:0]  flt_type,
    input ctl_state_e         ctrl_state,
    input logic [NUM_FLT-1:0] status,
    input logic               irq,
    input logic               req_ready,
    input logic               bypass,
    input logic               blocked,
    input logic               tlb_flush,
    input logic [31:0]        pt_base
);

    assert_one_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({req_ready, bypass, blocked}) == 1);

    assert_fault_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && ctrl_state != ST_OFF) |=> blocked);

    assert_fault_sets_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && ctrl_state != ST_OFF) |=> status[$past(flt_type)]);

    assert_fault_beats_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && ctrl_state != ST_OFF && reg_wr && reg_addr == RA_CTRL) |=> !req_ready);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_CLEAR && !flt_valid) |=> ((status & $past(wdata_lo)) == '0));

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> !irq);

    assert_flush_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_FLUSH && wdata_lo[0]) |=> tlb_flush);

    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == RA_FLUSH && wdata_lo[0]) |=> !tlb_flush);

    assert_base_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == RA_BASE) |=> $stable(pt_base));

endmodule

bind mmu_ctl_regs mmu_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .wdata_lo   (reg_wdata[7:0]),
    .flt_valid  (flt_valid),
    .flt_type   (flt_type),
    .ctrl_state (state_q),
    .status     (status_q),
    .irq        (irq),
    .req_ready  (req_ready),
    .bypass     (bypass),
    .blocked    (blocked),
    .tlb_flush  (tlb_flush),
    .pt_base    (32'(pt_base))
);

// File: tb/mmu_ctl_regs_tb.sv
// Self-checking bench for mmu_ctl_regs: full sweep of fault types plus races.
module mmu_ctl_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        flt_valid = 1'b0;
    logic [2:0]  flt_type = '0;
    logic [31:0] flt_addr = '0;
    logic        irq, req_ready, bypass, blocked, tlb_flush, tbl_small;
    logic [31:0] pt_base;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    mmu_ctl_regs #(.DW(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flt_valid(flt_valid),
        .flt_type(flt_type), .flt_addr(flt_addr), .irq(irq), .req_ready(req_ready),
        .bypass(bypass), .blocked(blocked), .tlb_flush(tlb_flush),
        .tbl_small(tbl_small), .pt_base(pt_base)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic fault(input logic [2:0] t, input logic [31:0] a);
        @(negedge clk);
        flt_valid = 1'b1; flt_type = t; flt_addr = a;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    // Address register offset for a fault type (R5)
    function automatic logic [3:0] addr_reg(input int t);
        case (t)
            0:       return 4'd6;
            1, 4, 5: return 4'd7;
            2, 6, 7: return 4'd8;
            default: return 4'd9;
        endcase
    endfunction

    // Another type in the same group (itself for single-member groups)
    function automatic int partner(input int t);
        case (t)
            1: return 4;  4: return 5;  5: return 1;
            2: return 6;  6: return 7;  7: return 2;
            default: return t;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(4'd0, d); check("R12 ctrl", d, 32'h0);
        rd(4'd4, d); check("R12 status", d, 32'h0);
        for (int r = 6; r <= 9; r++) begin
            rd(4'(r), d); check("R12 addr regs", d, 32'h0);
        end
        check("R12 outputs", {27'b0, bypass, req_ready, irq, tlb_flush, tbl_small}, 32'h10);
        check("R12 base", pt_base, 32'h0);

        // R1 control codes, R2 mode outputs
        wr(4'd0, 32'h5); rd(4'd0, d); check("R1 code 5", d, 32'h5);
        check("R2 xlate", {29'b0, bypass, req_ready, blocked}, 32'h2);
        wr(4'd0, 32'h3); rd(4'd0, d); check("R1 invalid ignored", d, 32'h5);
        wr(4'd0, 32'h7); rd(4'd0, d); check("R1 code 7", d, 32'h7);
        check("R2 block", {29'b0, bypass, req_ready, blocked}, 32'h1);
        wr(4'd0, 32'h0); rd(4'd0, d); check("R1 code 0", d, 32'h0);
        check("R2 off", {29'b0, bypass, req_ready, blocked}, 32'h4);

        // R3 fault while off is ignored
        fault(3'd2, 32'h1111_0000);
        rd(4'd4, d); check("R3 off ignores fault", d, 32'h0);
        check("R3 off stays bypass", {31'b0, bypass}, 32'h1);
        rd(4'd8, d); check("R3 off no capture", d, 32'h0);

        // R10 table size
        wr(4'd1, 32'h20); check("R10 small", {31'b0, tbl_small}, 32'h1);
        rd(4'd1, d); check("R10 readback", d, 32'h20);
        wr(4'd1, 32'h0); check("R10 large", {31'b0, tbl_small}, 32'h0);

        // R11 base
        wr(4'd2, 32'h1234_4000); check("R11 pt_base", pt_base, 32'h1234_4000);
        rd(4'd2, d); check("R11 readback", d, 32'h1234_4000);
        wr(4'd3, 32'h0); check("R11 base holds", pt_base, 32'h1234_4000);

        // R9 flush pulse
        wr(4'd3, 32'h1); check("R9 pulse", {31'b0, tlb_flush}, 32'h1);
        @(negedge clk); check("R9 one cycle", {31'b0, tlb_flush}, 32'h0);
        wr(4'd3, 32'h2); check("R9 no pulse", {31'b0, tlb_flush}, 32'h0);

        // R3/R5/R6/R8 sweep over all fault types
        for (int t = 0; t < 8; t++) begin
            wr(4'd0, 32'h5);
            wr(4'd5, 32'hFF);
            a0 = 32'hA000_0000 + 32'(t) * 32'h10 + 32'h1;
            fault(3'(t), a0);
            rd(4'd4, d); check("R3 status bit", d, 32'h1 << t);
            check("R3 blocked", {30'b0, req_ready, blocked}, 32'h1);
            check("R8 irq on", {31'b0, irq}, 32'h1);
            rd(addr_reg(t), d); check("R5 routed addr", d, a0);
            fault(3'(partner(t)), 32'hDEAD_0000 | 32'(t));
            rd(addr_reg(t), d); check("R6 addr kept", d, a0);
            rd(4'd4, d); check("R6 second bit", d, (32'h1 << t) | (32'h1 << partner(t)));
        end

        // R8 interrupt masked while off, status retained
        wr(4'd0, 32'h0);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        rd(4'd4, d); check("R8 status kept", 32'(d != 0), 32'h1);
        wr(4'd0, 32'h5);
        check("R8 irq back", {31'b0, irq}, 32'h1);

        // R7 selective clear
        wr(4'd5, 32'hFF);
        fault(3'd0, 32'h0000_0100);
        fault(3'd3, 32'h0000_0300);
        rd(4'd4, d); check("R7 two pending", d, 32'h09);
        wr(4'd5, 32'h01);
        rd(4'd4, d); check("R7 clear one", d, 32'h08);
        rd(4'd6, d); check("R5 page addr", d, 32'h0000_0100);
        rd(4'd9, d); check("R5 bus addr", d, 32'h0000_0300);

        // R7 set wins over same-cycle clear
        wr(4'd5, 32'hFF);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd5; reg_wdata = 32'h02;
        flt_valid = 1'b1; flt_type = 3'd1; flt_addr = 32'h0000_0777;
        @(negedge clk);
        reg_wr = 1'b0; flt_valid = 1'b0;
        rd(4'd4, d); check("R7 set beats clear", d, 32'h02);

        // R4 unblock write racing a fault
        wr(4'd5, 32'hFF);
        wr(4'd0, 32'h7);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h5;
        flt_valid = 1'b1; flt_type = 3'd6; flt_addr = 32'h0000_0666;
        @(negedge clk);
        reg_wr = 1'b0; flt_valid = 1'b0;
        check("R4 stays blocked", {30'b0, req_ready, blocked}, 32'h1);
        rd(4'd0, d); check("R4 ctrl code", d, 32'h7);
        rd(4'd8, d); check("R4 write addr", d, 32'h0000_0666);
        wr(4'd0, 32'h5);
        check("R4 unblock later", {30'b0, req_ready, blocked}, 32'h2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule